// File: doc/BRIEF.md
# Block-Phase Compression Controller

This block paces a differential table-coding compressor through two alternating phases. While it streams, samples leave the input buffer one per cycle whenever the buffer has one. Each of those samples passes through the difference path and is coded with the table currently in use. When a full block has been consumed, the controller stops taking samples. It launches the table-builder engine, which works from the statistics of the block just finished, and then waits for the engine to report completion.

On completion the freshly built table becomes the active one, and the next block is coded with it. The tables sit in two banks: the engine fills the idle bank while the other one codes, and a single strobe exchanges them. Until the first exchange after reset, a default fixed-length code is in use.

The controller bounds every calculation window with a watchdog. If the engine overruns, the controller raises a sticky error flag, keeps the old table and goes back to streaming. A single ready-for-data output tells the environment when it may push samples.

Top module: `blkphase_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, the controller is streaming, the active bank is 0, the default-table flag is high, the error flag is low, and neither the start strobe nor the swap strobe is asserted.
- R2: `pop_en` equals `smp_valid` while streaming and is 0 during the launch and wait phases.
- R3: In the cycle after the pop that completes a block, `calc_start` is high for exactly one cycle and no pop happens.
- R4: In the wait phase, `calc_done` raises `tbl_swap` in that same cycle. `tbl_bank` toggles at the next edge and streaming resumes in the next cycle.
- R5: `calc_done` outside the wait phase has no effect: there is no swap, the bank is unchanged and the phase is unchanged.
- R6: `tbl_default` is 1 from reset until the first swap and 0 from the cycle after it.
- R7: `rdy_for_data` is 1 exactly when the controller is streaming and `buf_full` is 0.
- R8: The watchdog covers the wait phase, whose cycles are numbered from 0. If `calc_done` has not arrived by wait cycle `WDOG_CYC-1`, `calc_timeout` goes high at the next edge and stays high until reset. The bank and default flag are kept, and streaming resumes. If `calc_done` arrives in that last cycle, it takes precedence.
- R9: A block is complete when the number of pops since the block began reaches `blk_len`, with a `blk_len` of 0 treated as 1. The count restarts at 0 for each new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Input buffer holds at least one sample |
| buf_full | input | 1 | Input buffer is full |
| blk_len | input | CNT_W | Samples per block (0 acts as 1) |
| calc_done | input | 1 | Table builder finished |
| pop_en | output | 1 | Move one sample from the buffer into the difference path |
| calc_start | output | 1 | One-cycle launch of the table builder |
| tbl_swap | output | 1 | One-cycle exchange of the active and built table banks |
| tbl_bank | output | 1 | Bank currently used for coding |
| tbl_default | output | 1 | Default fixed-length table in use |
| rdy_for_data | output | 1 | Environment may supply samples |
| calc_timeout | output | 1 | Sticky flag: the table calculation overran the watchdog |

## Verification
The bound checker watches the invariants that hold on every cycle:
- the start strobe is one cycle long;
- a swap needs done and always flips the bank;
- the bank is held when there is no swap;
- ready is blocked by a full buffer;
- the default flag can only fall on a swap, and the error flag, once set, stays set.

Some behaviour only the scenarios can show: the exact pop on which a block closes under gappy input and short or zero block lengths, that done is ignored while streaming, the full watchdog window expiring, and done winning on its final cycle. These are compared vector by vector against a model of the requirements.

// File: rtl/blkphase_pkg.sv
package blkphase_pkg;

    typedef enum logic [1:0] {
        PH_STREAM = 2'd0,
        PH_LAUNCH = 2'd1,
        PH_WAIT   = 2'd2
    } phase_e;

    typedef struct packed {
        logic bank;
        logic dflt;
        logic err;
    } tbl_state_t;

    // True when 'seen' samples complete a block of length 'len' (0 acts as 1).
    function automatic logic block_full(input int unsigned seen, input int unsigned len);
        int unsigned eff;
        eff = (len == 0) ? 1 : len;
        return seen >= eff;
    endfunction

endpackage

// File: rtl/blkphase_cnt.sv
module blkphase_cnt
    import blkphase_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pop,
    input  logic [CNT_W-1:0] blk_len,
    output logic             last
);
    logic [CNT_W-1:0] seen_q;

    always_comb begin
        last = pop && block_full(32'(seen_q) + 32'd1, 32'(blk_len));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else if (last) begin
            seen_q <= '0;
        end else if (pop) begin
            seen_q <= seen_q + 1'b1;
        end
    end
endmodule

// File: rtl/blkphase_wdog.sv
module blkphase_wdog #(
    parameter int WDOG_CYC = 4175
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expire
);
    localparam int WD_W = (WDOG_CYC > 1) ? $clog2(WDOG_CYC) : 1;
    localparam logic [WD_W-1:0] WD_LAST = WD_W'(WDOG_CYC - 1);

    logic [WD_W-1:0] tick_q;

    assign expire = run && (tick_q == WD_LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tick_q <= '0;
        end else if (run && !expire) begin
            tick_q <= tick_q + 1'b1;
        end
    end
endmodule

// File: rtl/blkphase_seq.sv
module blkphase_seq
    import blkphase_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   last,
    input  logic   calc_done,
    input  logic   wd_expire,
    output phase_e phase,
    output logic   start,
    output logic   swap,
    output logic   overrun
);
    phase_e ph_q, ph_d;

    assign phase   = ph_q;
    assign start   = (ph_q == PH_LAUNCH);
    assign swap    = (ph_q == PH_WAIT) && calc_done;
    assign overrun = (ph_q == PH_WAIT) && !calc_done && wd_expire;

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_STREAM: if (last) ph_d = PH_LAUNCH;
            PH_LAUNCH: ph_d = PH_WAIT;
            PH_WAIT:   if (calc_done || wd_expire) ph_d = PH_STREAM;
            default:   ph_d = PH_STREAM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_STREAM;
        else     ph_q <= ph_d;
    end
endmodule

// File: rtl/blkphase_bank.sv
module blkphase_bank
    import blkphase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       swap,
    input  logic       overrun,
    output tbl_state_t st
);
    tbl_state_t st_q;

    assign st = st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{bank: 1'b0, dflt: 1'b1, err: 1'b0};
        end else begin
            if (swap) begin
                st_q.bank <= ~st_q.bank;
                st_q.dflt <= 1'b0;
            end
            if (overrun) st_q.err <= 1'b1;
        end
    end
endmodule

// File: rtl/blkphase_ctrl.sv
module blkphase_ctrl
    import blkphase_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int WDOG_CYC = 4175
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic             buf_full,
    input  logic [CNT_W-1:0] blk_len,
    input  logic             calc_done,
    output logic             pop_en,
    output logic             calc_start,
    output logic             tbl_swap,
    output logic             tbl_bank,
    output logic             tbl_default,
    output logic             rdy_for_data,
    output logic             calc_timeout
);
    phase_e     phase;
    logic       last, wd_expire, overrun;
    tbl_state_t tst;

    assign pop_en       = (phase == PH_STREAM) && smp_valid;
    assign rdy_for_data = (phase == PH_STREAM) && !buf_full;
    assign tbl_bank     = tst.bank;
    assign tbl_default  = tst.dflt;
    assign calc_timeout = tst.err;

    blkphase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .pop(pop_en), .blk_len(blk_len), .last(last)
    );

    blkphase_seq u_seq (
        .clk(clk), .rst(rst), .last(last), .calc_done(calc_done),
        .wd_expire(wd_expire), .phase(phase), .start(calc_start),
        .swap(tbl_swap), .overrun(overrun)
    );

    blkphase_wdog #(.WDOG_CYC(WDOG_CYC)) u_wdog (
        .clk(clk), .rst(rst), .clr(calc_start),
        .run(phase == PH_WAIT), .expire(wd_expire)
    );

    blkphase_bank u_bank (
        .clk(clk), .rst(rst), .swap(tbl_swap), .overrun(overrun), .st(tst)
    );
endmodule

// File: rtl/blkphase_chk.sv
module blkphase_chk #(
    parameter int CNT_W    = 10,
    parameter int WDOG_CYC = 4175
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_valid,
    input logic             buf_full,
    input logic [CNT_W-1:0] blk_len,
    input logic             calc_done,
    input logic             pop_en,
    input logic             calc_start,
    input logic             tbl_swap,
    input logic             tbl_bank,
    input logic             tbl_default,
    input logic             rdy_for_data,
    input logic             calc_timeout
);
    p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        calc_start |=> !calc_start);

    p_start_no_pop_r3: assert property (@(posedge clk) disable iff (rst)
        calc_start |-> !pop_en);

    p_swap_flip_r4: assert property (@(posedge clk) disable iff (rst)
        tbl_swap |=> (tbl_bank != $past(tbl_bank)));

    p_swap_done_r4: assert property (@(posedge clk) disable iff (rst)
        tbl_swap |-> calc_done);

    p_bank_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !tbl_swap |=> $stable(tbl_bank));

    p_dflt_fall_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(tbl_default) |-> $past(tbl_swap));

    p_rdy_full_r7: assert property (@(posedge clk) disable iff (rst)
        buf_full |-> !rdy_for_data);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        calc_timeout |=> calc_timeout);

    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pop_en, calc_start, tbl_swap}));
endmodule

bind blkphase_ctrl blkphase_chk #(.CNT_W(CNT_W), .WDOG_CYC(WDOG_CYC)) u_chk (.*);

// File: tb/sim_blkphase_ctrl.sv
module sim_blkphase_ctrl;
    localparam int CNT_W = 10;
    localparam int WDOG  = 4175;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0, buf_full = 1'b0, calc_done = 1'b0;
    logic [CNT_W-1:0] blk_len = 10'd4;
    logic pop_en, calc_start, tbl_swap, tbl_bank, tbl_default, rdy_for_data, calc_timeout;

    always #10 clk = ~clk;

    blkphase_ctrl #(.CNT_W(CNT_W), .WDOG_CYC(WDOG)) u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .buf_full(buf_full),
        .blk_len(blk_len), .calc_done(calc_done), .pop_en(pop_en),
        .calc_start(calc_start), .tbl_swap(tbl_swap), .tbl_bank(tbl_bank),
        .tbl_default(tbl_default), .rdy_for_data(rdy_for_data),
        .calc_timeout(calc_timeout)
    );

    typedef struct {
        logic pop, start, swap, bank, dflt, rdy, err;
        string tag;
    } exp_t;

    exp_t q[$];
    event ev;
    int vectors = 0, fails = 0;
    bit done_flag = 0;

    // model state: 0 stream, 1 launch, 2 wait
    int m_ph, m_cnt, m_w;
    logic m_bank, m_dflt, m_err;

    task automatic model_reset();
        m_ph = 0; m_cnt = 0; m_w = 0;
        m_bank = 0; m_dflt = 1; m_err = 0;
    endtask

    task automatic chk(string req, string tag, logic act, logic exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] t=%0t actual=%0b expected=%0b", req, tag, $time, act, exp);
        end
    endtask

    // driver: drive one cycle of inputs, push expectation, advance model
    task automatic step(logic v, logic f, logic d, int len, string tag);
        exp_t e;
        int eff;
        @(negedge clk);
        smp_valid = v; buf_full = f; calc_done = d; blk_len = CNT_W'(len);
        e.pop = (m_ph == 0) && v;
        e.start = (m_ph == 1);
        e.swap = (m_ph == 2) && d;
        e.rdy = (m_ph == 0) && !f;
        e.bank = m_bank; e.dflt = m_dflt; e.err = m_err;
        e.tag = tag;
        #2;
        q.push_back(e);
        ->ev;
        eff = (len == 0) ? 1 : len;
        case (m_ph)
            0: if (v) begin
                   if (m_cnt + 1 >= eff) begin m_ph = 1; m_cnt = 0; end
                   else m_cnt++;
               end
            1: begin m_ph = 2; m_w = 0; end
            default: begin
                if (d) begin m_bank = ~m_bank; m_dflt = 0; m_ph = 0; end
                else if (m_w == WDOG - 1) begin m_err = 1; m_ph = 0; end
                else m_w++;
            end
        endcase
    endtask

    // monitor: pop expectation, compare against the ports
    initial begin
        forever begin
            exp_t e;
            @(ev);
            e = q.pop_front();
            vectors++;
            chk("R2", e.tag, pop_en, e.pop);
            chk("R3", e.tag, calc_start, e.start);
            chk("R4", e.tag, tbl_swap, e.swap);
            chk("R5", e.tag, tbl_bank, e.bank);
            chk("R6", e.tag, tbl_default, e.dflt);
            chk("R7", e.tag, rdy_for_data, e.rdy);
            chk("R8", e.tag, calc_timeout, e.err);
        end
    end

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung actual=running expected=finished");
        summary();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state seen on the first vector
        step(0, 0, 0, 4, "R1");
        step(1, 0, 1, 4, "R5 done while streaming");
        // R9: block of 4 with continuous samples, then wait and done
        repeat (5) step(1, 0, 0, 4, "R9 len4");
        repeat (3) step(1, 1, 0, 4, "R7 full in wait");
        step(1, 0, 1, 4, "R4 swap");
        // gappy input with buffer-full toggling
        for (int i = 0; i < 12; i++) step(i % 3 != 0, i % 2 == 0, 0, 4, "R2 gaps");
        repeat (4) step(0, 0, 0, 4, "R5 idle wait");
        step(0, 0, 1, 4, "R4 second swap");
        // R9: blk_len 0 acts as 1
        for (int i = 0; i < 9; i++) step(1, 0, i % 3 == 2, 0, "R9 len0");
        // R8: let the watchdog expire
        repeat (3) step(1, 0, 0, 2, "R8 lead");
        for (int i = 0; i < WDOG + 4; i++) step(0, 0, 0, 2, "R8 expire");
        // R8: done on the final watchdog cycle wins
        repeat (2) step(1, 0, 0, 2, "R8 lead2");
        step(0, 0, 0, 2, "R8 launch");
        for (int i = 0; i < WDOG - 1; i++) step(0, 0, 0, 2, "R8 wait");
        step(0, 0, 1, 2, "R8 done on last");
        repeat (4) step(1, 0, 0, 3, "R3 after");
        @(negedge clk);
        #5;
        summary();
    end
endmodule